// File: doc/BRIEF.md
# Multi-Channel Auto-Reload PWM Timer

This block produces up to four pulse-width-modulated outputs that share one frequency. An 8-bit up-counter advances on every cycle in which the counter clock enable is high and the halt input is low. After it reaches its all-ones value the counter does not wrap to zero. It restarts from a programmable floor value. The floor therefore sets two things at once: the period, which is 256 minus the floor in counter ticks, and the number of distinct duty steps.

Each channel has a compare register that is loaded from a shadow copy, an enable bit and a polarity bit. At every counter overflow an enabled output moves to its active level. When the counter reaches the channel's compare value the output falls back to its inactive level. Software writes duty values into the shadow copies at any time. A new value takes effect only when the current period ends, so no period is cut short or stretched. The outputs can reach both 0% and 100% duty: set the compare value at or below the floor, then choose the polarity bit.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset, every `pwm_out` bit and every `pwm_oe` bit is 0, the counter is 0, and all enables, polarity bits, the floor, the shadow registers and the compare registers are 0.
- R2: A write with `wr_en` high is stored on the clock edge. Address 0 is control: bits [3:0] are the enables of channels 0..3 and also drive `pwm_oe`, and bits [7:4] are the polarity bits of channels 0..3. Address 1 is the reload floor. Address 4+i is the duty shadow of channel i. Addresses 2 and 3 are ignored.
- R3: On each cycle with `cnt_en`=1 and `halt`=0 the counter increments, and from 255 it loads the floor. One period is therefore 256 minus the floor in active cycles.
- R4: With polarity 0 and compare value C greater than floor F, an enabled output is high for C−F cycles of each period and low for the rest. It rises at the overflow and falls when the counter reaches C.
- R5: With polarity 1, an enabled output is the inverse of the R4 waveform, so it is high for (256−F)−(C−F) cycles of each period.
- R6: When C ≤ F, an enabled output never toggles. It is constantly low with polarity 0 (0% duty) and constantly high with polarity 1 (100% duty).
- R7: An output whose enable bit is 0 is held at its inactive level, which equals its polarity bit, whatever its duty value.
- R8: A duty write goes to the shadow register. The compare value copies the shadow only at a counter overflow, so the pulse that is already running keeps its old length.
- R9: If a duty write is captured on the same edge as an overflow, the period that starts on that edge uses the earlier shadow value. The written value applies from the following overflow.
- R10: While `halt` is 1 the counter and all outputs hold still. When `halt` returns to 0 the waveform continues.
- R11: While `cnt_en` is 0 the counter and all outputs hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter clock enable (one tick per high cycle) |
| halt | input | 1 | Freezes PWM generation while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | PWM outputs, channel i on bit i |
| pwm_oe | output | 4 | Per-channel output-enable flags |

## Verification
Two events can fall on the same clock edge: a duty-register write and the counter overflow that moves the shadow into the compare register. The bench provokes this with a short 4-tick period. It locks onto a rising output edge, then places a write so that it is captured exactly on the next overflow edge. The test passes if the pulse that starts on that edge still has the old width and the new width appears one period later. A separate case writes in the middle of a pulse and checks that the running pulse is not shortened.

// File: rtl/pwm_rt_pkg.sv
package pwm_rt_pkg;
   // low-half register selectors (address MSB = 0)
   localparam int unsigned SEL_CTRL   = 0;
   localparam int unsigned SEL_FLOOR  = 1;
   // polarity bits start at this bit of the control word
   localparam int unsigned POL_LSB    = 4;
   localparam int unsigned MAX_CH     = 4;
endpackage

// File: rtl/pwm_rt_counter.sv
module pwm_rt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             halt,
   input  logic [CNT_W-1:0] floor_val,
   output logic             tick,
   output logic             ovf,
   output logic [CNT_W-1:0] cnt_next
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   assign tick     = cnt_en & ~halt;
   assign ovf      = tick & (cnt_q == TOP);
   assign cnt_next = (cnt_q == TOP) ? floor_val : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_next;
   end

   assert_reload_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> cnt_q == $past(floor_val));
   assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ovf) |=> cnt_q == $past(cnt_q) + 1'b1);
   assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(cnt_q));
   assert_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_rt_regs.sv
module pwm_rt_regs
   import pwm_rt_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int NCH   = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W:0]   wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [NCH-1:0]   ch_en,
   output logic [NCH-1:0]   ch_pol,
   output logic [CNT_W-1:0] floor_val,
   output logic [NCH-1:0]   duty_we
);
   logic hi_sel, wr_ctrl, wr_floor;

   assign hi_sel   = wr_addr[IDX_W];
   assign wr_ctrl  = wr_en & ~hi_sel & (wr_addr[IDX_W-1:0] == IDX_W'(SEL_CTRL));
   assign wr_floor = wr_en & ~hi_sel & (wr_addr[IDX_W-1:0] == IDX_W'(SEL_FLOOR));

   for (genvar i = 0; i < NCH; i++) begin : g_we
      assign duty_we[i] = wr_en & hi_sel & (wr_addr[IDX_W-1:0] == IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_en     <= '0;
         ch_pol    <= '0;
         floor_val <= '0;
      end else begin
         if (wr_ctrl) begin
            ch_en  <= wr_data[NCH-1:0];
            ch_pol <= wr_data[POL_LSB +: NCH];
         end
         if (wr_floor) floor_val <= wr_data;
      end
   end

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ch_en == $past(wr_data[NCH-1:0]));
   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ch_pol) && $stable(ch_en));
   assert_one_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(duty_we));
endmodule

// File: rtl/pwm_rt_channel.sv
module pwm_rt_channel #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ovf,
   input  logic [CNT_W-1:0] cnt_next,
   input  logic [CNT_W-1:0] floor_val,
   input  logic             duty_we,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             en,
   input  logic             pol,
   output logic             pwm
);
   logic [CNT_W-1:0] shadow_q, cmp_q;
   logic             lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         cmp_q    <= '0;
         lvl_q    <= 1'b0;
      end else begin
         if (duty_we) shadow_q <= wr_data;
         if (ovf)     cmp_q    <= shadow_q;
         if (ovf)
            lvl_q <= (shadow_q > floor_val);
         else if (tick && (cnt_next == cmp_q))
            lvl_q <= 1'b0;
      end
   end

   assign pwm = en ? (lvl_q ^ pol) : pol;

   assert_shadow_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> cmp_q == $past(shadow_q));
   assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf |=> $stable(cmp_q));
   assert_level_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(lvl_q));
   assert_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(shadow_q > floor_val)) |=> !lvl_q);
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
   import pwm_rt_pkg::*;
#(
   parameter  int CNT_W = 8,
   parameter  int NCH   = 4,
   localparam int IDX_W = (NCH > 2) ? $clog2(NCH) : 1,
   localparam int AW    = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             halt,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [NCH-1:0]   pwm_out,
   output logic [NCH-1:0]   pwm_oe
);
   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("pwm_reload_timer: NCH out of range");
   end
   if (CNT_W < 2 * MAX_CH || CNT_W > 16) begin : g_bad_w
      $error("pwm_reload_timer: CNT_W must hold the control word");
   end

   logic             tick, ovf;
   logic [CNT_W-1:0] cnt_next, floor_val;
   logic [NCH-1:0]   ch_en, ch_pol, duty_we;

   pwm_rt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .halt(halt),
      .floor_val(floor_val), .tick(tick), .ovf(ovf), .cnt_next(cnt_next));

   pwm_rt_regs #(.CNT_W(CNT_W), .NCH(NCH), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ch_en(ch_en), .ch_pol(ch_pol),
      .floor_val(floor_val), .duty_we(duty_we));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwm_rt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .ovf(ovf),
         .cnt_next(cnt_next), .floor_val(floor_val),
         .duty_we(duty_we[i]), .wr_data(wr_data),
         .en(ch_en[i]), .pol(ch_pol[i]), .pwm(pwm_out[i]));
   end

   assign pwm_oe = ch_en;

   assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwm_oe & (pwm_out ^ ch_pol)) == pwm_out ^ ch_pol));
endmodule

// File: tb/pwm_reload_timer_bench.sv
module pwm_reload_timer_bench;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [7:0] rl;
      logic [7:0] d0, d1, d2, d3;
      logic [3:0] pol;
      logic [8:0] e0, e1, e2, e3;
   } vec_t;

   // expected = high cycles of each channel over one period
   localparam vec_t VECS [6] = '{
      '{8'h00, 8'h80, 8'h40, 8'hFF, 8'h00, 4'b0000, 9'd128, 9'd64,  9'd255, 9'd0},
      '{8'h00, 8'h80, 8'h40, 8'hFF, 8'h00, 4'b1111, 9'd128, 9'd192, 9'd1,   9'd256},
      '{8'hC0, 8'hE0, 8'hC1, 8'hC0, 8'h10, 4'b0000, 9'd32,  9'd1,   9'd0,   9'd0},
      '{8'hC0, 8'hE0, 8'hC1, 8'hC0, 8'h10, 4'b1100, 9'd32,  9'd1,   9'd64,  9'd64},
      '{8'hFD, 8'hFE, 8'hFF, 8'hFD, 8'h00, 4'b0000, 9'd1,   9'd2,   9'd0,   9'd0},
      '{8'hF0, 8'hF8, 8'hF1, 8'hFF, 8'hF0, 4'b0101, 9'd8,   9'd1,   9'd1,   9'd0}
   };

   logic       clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b1, halt = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] pwm_out, pwm_oe;
   int n_chk = 0, n_bad = 0;

   pwm_reload_timer u_pwm_reload_timer (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .halt(halt), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_high(input int len, output int hi [4]);
      for (int c = 0; c < 4; c++) hi[c] = 0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         for (int c = 0; c < 4; c++) if (pwm_out[c]) hi[c]++;
      end
   endtask

   task automatic run_len(output int n);
      n = 0;
      while (pwm_out[0]) begin n++; @(negedge clk); end
   endtask

   task automatic to_rise();
      while (pwm_out[0])  @(negedge clk);
      while (!pwm_out[0]) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi [4];
      int first, n, changes;
      logic [3:0] ref_out;
      repeat (3) @(negedge clk);
      check("R1 pwm_out after reset", int'(pwm_out), 0);
      check("R1 pwm_oe after reset", int'(pwm_oe), 0);
      rst_n = 1'b1;

      // vector table walk: R2 R3 R4 R5 R6
      foreach (VECS[v]) begin
         wr(3'd1, VECS[v].rl);
         wr(3'd4, VECS[v].d0);
         wr(3'd5, VECS[v].d1);
         wr(3'd6, VECS[v].d2);
         wr(3'd7, VECS[v].d3);
         wr(3'd0, {VECS[v].pol, 4'hF});
         repeat (600) @(negedge clk);
         count_high(256 - int'(VECS[v].rl), hi);
         check("R4/R5/R6 ch0 duty", hi[0], int'(VECS[v].e0));
         check("R4/R5/R6 ch1 duty", hi[1], int'(VECS[v].e1));
         check("R4/R5/R6 ch2 duty", hi[2], int'(VECS[v].e2));
         check("R4/R5/R6 ch3 duty", hi[3], int'(VECS[v].e3));
      end
      check("R2 pwm_oe follows enables", int'(pwm_oe), 15);

      // R7: disabled channels drive their polarity level
      wr(3'd0, 8'hF0);
      count_high(256, hi);
      check("R7 disabled pol1 ch0 high count", hi[0], 256);
      check("R7 disabled pol1 ch3 high count", hi[3], 256);
      check("R7 pwm_oe cleared", int'(pwm_oe), 0);
      wr(3'd0, 8'h00);
      count_high(256, hi);
      check("R7 disabled pol0 ch1 high count", hi[1], 0);

      // ignored address 2 leaves floor untouched (R2, R3)
      wr(3'd1, 8'h00);
      wr(3'd4, 8'h80);
      wr(3'd0, 8'h01);
      wr(3'd2, 8'hF0);
      repeat (600) @(negedge clk);
      count_high(256, hi);
      check("R2 address 2 ignored, period kept", hi[0], 128);

      // R8: write in the middle of a pulse
      to_rise();
      wr(3'd4, 8'h10);
      run_len(n);
      check("R8 running pulse keeps old width", n + 2, 128);
      to_rise();
      run_len(n);
      check("R8 new width after overflow", n, 16);

      // R9: write captured on the overflow edge
      wr(3'd1, 8'hFC);
      wr(3'd4, 8'hFE);
      repeat (40) @(negedge clk);
      to_rise();
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'hFD;
      @(negedge clk);
      wr_en = 1'b0;
      run_len(n);
      check("R9 period on write edge uses old shadow", n, 2);
      to_rise();
      run_len(n);
      check("R9 written value on next period", n, 1);

      // R10: halt freezes outputs, then resumes
      wr(3'd1, 8'h00);
      wr(3'd4, 8'h80);
      repeat (600) @(negedge clk);
      repeat (37) @(negedge clk);
      halt = 1'b1;
      @(negedge clk);
      ref_out = pwm_out;
      changes = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (pwm_out != ref_out) changes++;
      end
      check("R10 outputs frozen in halt", changes, 0);
      halt = 1'b0;
      count_high(256, hi);
      check("R10 waveform resumes after halt", hi[0], 128);

      // R11: counter enable low freezes outputs
      repeat (91) @(negedge clk);
      cnt_en = 1'b0;
      @(negedge clk);
      ref_out = pwm_out;
      changes = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (pwm_out != ref_out) changes++;
      end
      check("R11 outputs frozen without cnt_en", changes, 0);
      cnt_en = 1'b1;
      count_high(256, hi);
      check("R11 waveform resumes", hi[0], 128);

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      first = int'(pwm_out);
      check("R1 reset mid-run outputs", first, 0);
      check("R1 reset mid-run enables", int'(pwm_oe), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule